// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single control-word write on a small 32-bit register bus into a complete NAND flash transaction on the flash pins. The transaction is a first command byte, then zero to five address bytes, then an optional second command byte (read-start, program-confirm or erase-confirm), then a data phase in the read or write direction. Before a read data phase, and before the block signals completion, the block waits for the device's ready/busy line.

Software loads the second-command, address and length registers and pushes any write bytes into the write FIFO. It then writes the control word with the valid bit set. The sequencer takes a snapshot of all these values when it accepts the launch, drives CLE, ALE, WE#, RE#, one of two chip enables and the data bus with fixed strobe timing, and collects read bytes into a FIFO that software drains through a data register. When the transaction ends, a sticky done bit is set and drives a level interrupt. Software clears the done bit by writing 1 to it.

Register word index on `reg_addr_i`: 0 control word (launch), 1 second command, 2 address low, 3 address high, 4 data length, 5 status, 6 read data, 7 write data.

Top module: `nand_seq_top`

## Requirements
- R1: A write to index 0 with bit 31 set starts a transaction when the block is idle. A write with bit 31 clear starts nothing. A read of index 0 returns the last accepted control word.
- R2: A command byte is driven with CLE high, ALE low and the opcode (control bits 7:0) on the data bus. It is strobed by one WE# pulse that is PULSE_CYC cycles low followed by PULSE_CYC cycles high. The data bus is unchanged across the rising WE# edge.
- R3: Control bit 30 flags that address cycles are present, and bits 29:27 hold the count minus one (values above 4 are clamped to five cycles). The address is {index 3 bits 23:0, index 2 bits 15:0}. It is sent least-significant byte first, one WE# pulse per byte, with ALE high and CLE low.
- R4: When index 1 bit 8 is set, the byte in index 1 bits 7:0 is sent as a second command. For read and no-data transactions it follows the address cycles; for write transactions it follows the data bytes. When bit 8 is clear, no second command is sent.
- R5: Control bit 26 selects a read data phase and bit 25 selects a write data phase. The phase carries as many bytes as index 4 holds. With neither bit set, there is no data phase.
- R6: A read phase gives one RE# pulse per byte. The byte on the flash bus is captured while RE# is low and queued in order. Each read of index 6 returns the oldest queued byte in bits 7:0 and removes it.
- R7: Writes to index 6… to index 7 queue bytes (bits 7:0). A write phase sends them in order with CLE and ALE low, one WE# pulse each. When the queue is empty, 0xFF is sent.
- R8: Control bit 19 set drives chip enable 1 low (nand_ce_no = 2'b01); clear drives chip enable 0 low (2'b10). The chosen line stays low for the whole transaction, and both lines are high when idle.
- R9: After the last command, address or write byte, the block waits up to TWB_CYC cycles for R/B# to go low. If it does, the block then waits for R/B# high. Only after that does it start the read phase or complete. If R/B# never goes low within the window, the block continues.
- R10: Completion sets status bit 31, and irq_o follows that bit. Writing 1 to status bit 31 clears it. Writing 0 leaves it set.
- R11: Status bit 0 reads 1 from launch until the cycle done is set. Control-word writes during that time are ignored.
- R12: After reset, both chip enables, WE# and RE# are high, CLE, ALE, the bus enable and irq_o are low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the read queue at index 6) |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt, equal to the done bit |
| nand_ce_no | output | 2 | Chip enables, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Flash data bus out |
| nand_dq_oe_o | output | 1 | Flash data bus output enable |
| nand_dq_i | input | 8 | Flash data bus in |
| nand_rb_ni | input | 1 | Ready/busy, low while busy |

## Verification
The assertions take as given that R/B# and the flash data bus are synchronous to clk_i, and that the flash data bus holds steady while RE# is low. They also assume the register bus issues at most one access per cycle. The bench's flash model changes R/B# and its read data only on the falling clock edge. It drives busy only a few cycles after it sees a confirm opcode latched, and it advances read data only after RE# rises. Register accesses are one-cycle pulses placed between rising edges.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [2:0] RA_LAUNCH  = 3'd0;
  localparam logic [2:0] RA_CMD2    = 3'd1;
  localparam logic [2:0] RA_ADDR_LO = 3'd2;
  localparam logic [2:0] RA_ADDR_HI = 3'd3;
  localparam logic [2:0] RA_DLEN    = 3'd4;
  localparam logic [2:0] RA_STAT    = 3'd5;
  localparam logic [2:0] RA_RDATA   = 3'd6;
  localparam logic [2:0] RA_WDATA   = 3'd7;

  localparam int CW_VALID  = 31;
  localparam int CW_APRES  = 30;
  localparam int CW_ACNT   = 27;
  localparam int CW_RD     = 26;
  localparam int CW_WR     = 25;
  localparam int CW_CESEL  = 19;
  localparam int C2_EN     = 8;
  localparam int ST_DONE   = 31;
  localparam int ST_BUSY   = 0;
  localparam int MAX_ADDR  = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DATA_W, S_CMD2,
    S_WAIT_LO, S_WAIT_HI, S_DATA_R, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0] op;
    logic       ce_sel;
    logic       rd;
    logic       wr;
    logic [2:0] naddr;
    logic [7:0] cmd2;
    logic       cmd2_en;
  } seq_cmd_t;
endpackage

// File: rtl/nand_seq_fifo.sv
module nand_seq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rp_q];
  assign do_push = push_i && (cnt_q != C_FULL);
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == P_LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == P_LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int DLEN_W = 12,
  parameter int AHI_W  = 24,
  localparam int AW    = 16 + AHI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic [7:0]        rf_head_i,
  output logic              rf_pop_o,
  output logic              wf_push_o,
  output logic              launch_o,
  output seq_cmd_t          cmd_o,
  output logic [AW-1:0]     addr_o,
  output logic [DLEN_W-1:0] dlen_o,
  output logic              done_o
);
  logic [31:0]       ctrl_q;
  logic [8:0]        cmd2_q;
  logic [15:0]       alo_q;
  logic [AHI_W-1:0]  ahi_q;
  logic [DLEN_W-1:0] dlen_q;
  logic              done_q;
  logic              wr_stat;

  assign launch_o  = reg_wr_i && (reg_addr_i == RA_LAUNCH) && reg_wdata_i[CW_VALID] && !busy_i;
  assign wf_push_o = reg_wr_i && (reg_addr_i == RA_WDATA);
  assign rf_pop_o  = reg_rd_i && (reg_addr_i == RA_RDATA);
  assign wr_stat   = reg_wr_i && (reg_addr_i == RA_STAT);

  always_comb begin
    cmd_o.op      = reg_wdata_i[7:0];
    cmd_o.ce_sel  = reg_wdata_i[CW_CESEL];
    cmd_o.rd      = reg_wdata_i[CW_RD];
    cmd_o.wr      = reg_wdata_i[CW_WR];
    if (!reg_wdata_i[CW_APRES])                    cmd_o.naddr = 3'd0;
    else if (reg_wdata_i[CW_ACNT+2:CW_ACNT] >= 3'd4) cmd_o.naddr = 3'(MAX_ADDR);
    else                                           cmd_o.naddr = reg_wdata_i[CW_ACNT+2:CW_ACNT] + 3'd1;
    cmd_o.cmd2    = cmd2_q[7:0];
    cmd_o.cmd2_en = cmd2_q[C2_EN];
  end

  assign addr_o = {ahi_q, alo_q};
  assign dlen_o = dlen_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmd2_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      dlen_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (launch_o) ctrl_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == RA_CMD2)    cmd2_q <= reg_wdata_i[8:0];
      if (reg_wr_i && reg_addr_i == RA_ADDR_LO) alo_q  <= reg_wdata_i[15:0];
      if (reg_wr_i && reg_addr_i == RA_ADDR_HI) ahi_q  <= reg_wdata_i[AHI_W-1:0];
      if (reg_wr_i && reg_addr_i == RA_DLEN)    dlen_q <= reg_wdata_i[DLEN_W-1:0];
      // set wins over a same-cycle clear
      if (done_set_i)                             done_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_DONE])   done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_LAUNCH:  reg_rdata_o = ctrl_q;
      RA_CMD2:    reg_rdata_o = 32'(cmd2_q);
      RA_ADDR_LO: reg_rdata_o = 32'(alo_q);
      RA_ADDR_HI: reg_rdata_o = 32'(ahi_q);
      RA_DLEN:    reg_rdata_o = 32'(dlen_q);
      RA_STAT:    reg_rdata_o = {done_q, 30'b0, busy_i};
      RA_RDATA:   reg_rdata_o = 32'(rf_head_i);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int DLEN_W    = 12,
  parameter int AW        = 40,
  parameter int PULSE_CYC = 2,
  parameter int TWB_CYC   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  seq_cmd_t          cmd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DLEN_W-1:0] dlen_i,
  input  logic              wf_empty_i,
  input  logic [7:0]        wf_head_i,
  output logic              wf_pop_o,
  output logic              rf_push_o,
  output logic [7:0]        rf_data_o,
  output logic              busy_o,
  output logic              done_set_o,
  output logic [1:0]        ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  input  logic [7:0]        dq_i,
  input  logic              rb_ni
);
  localparam int TW = $clog2(2 * PULSE_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(2 * PULSE_CYC - 1);
  localparam logic [TW-1:0] T_SAMP = TW'(PULSE_CYC - 1);
  localparam int WW = $clog2(TWB_CYC + 1);
  localparam logic [WW-1:0] W_LAST = WW'(TWB_CYC - 1);

  seq_state_e        state_q, after_addr, after_wait;
  seq_cmd_t          cmd_q;
  logic [AW-1:0]     addr_q;
  logic [DLEN_W-1:0] len_q;
  logic [TW-1:0]     tmr_q;
  logic [WW-1:0]     wcnt_q;
  logic              in_step, step_end, strobe_lo, wr_strobe;

  assign in_step   = state_q inside {S_CMD1, S_ADDR, S_DATA_W, S_CMD2, S_DATA_R};
  assign wr_strobe = state_q inside {S_CMD1, S_ADDR, S_DATA_W, S_CMD2};
  assign step_end  = in_step && (tmr_q == T_LAST);
  assign strobe_lo = tmr_q <= T_SAMP;

  always_comb begin
    if (cmd_q.wr && len_q != '0) after_addr = S_DATA_W;
    else if (cmd_q.cmd2_en)      after_addr = S_CMD2;
    else                         after_addr = S_WAIT_LO;
    after_wait = (cmd_q.rd && len_q != '0) ? S_DATA_R : S_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      tmr_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      tmr_q  <= (in_step && !step_end) ? tmr_q + 1'b1 : '0;
      wcnt_q <= (state_q == S_WAIT_LO) ? wcnt_q + 1'b1 : '0;
      unique case (state_q)
        S_IDLE: if (launch_i) begin
          cmd_q   <= cmd_i;
          addr_q  <= addr_i;
          len_q   <= dlen_i;
          state_q <= S_CMD1;
        end
        S_CMD1: if (step_end) state_q <= (cmd_q.naddr != '0) ? S_ADDR : after_addr;
        S_ADDR: if (step_end) begin
          addr_q      <= addr_q >> 8;
          cmd_q.naddr <= cmd_q.naddr - 3'd1;
          if (cmd_q.naddr == 3'd1) state_q <= after_addr;
        end
        S_DATA_W: if (step_end) begin
          len_q <= len_q - 1'b1;
          if (len_q == DLEN_W'(1)) state_q <= cmd_q.cmd2_en ? S_CMD2 : S_WAIT_LO;
        end
        S_CMD2: if (step_end) state_q <= S_WAIT_LO;
        S_WAIT_LO: begin
          if (!rb_ni)                state_q <= S_WAIT_HI;
          else if (wcnt_q == W_LAST) state_q <= after_wait;
        end
        S_WAIT_HI: if (rb_ni) state_q <= after_wait;
        S_DATA_R: if (step_end) begin
          len_q <= len_q - 1'b1;
          if (len_q == DLEN_W'(1)) state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign done_set_o = state_q == S_DONE;
  assign ce_no      = !busy_o ? 2'b11 : (cmd_q.ce_sel ? 2'b01 : 2'b10);
  assign cle_o      = state_q inside {S_CMD1, S_CMD2};
  assign ale_o      = state_q == S_ADDR;
  assign we_no      = !(wr_strobe && strobe_lo);
  assign re_no      = !(state_q == S_DATA_R && strobe_lo);
  assign dq_oe_o    = wr_strobe;
  assign wf_pop_o   = (state_q == S_DATA_W) && step_end;
  assign rf_push_o  = (state_q == S_DATA_R) && (tmr_q == T_SAMP);
  assign rf_data_o  = dq_i;

  always_comb begin
    unique case (state_q)
      S_CMD1:   dq_o = cmd_q.op;
      S_ADDR:   dq_o = addr_q[7:0];
      S_DATA_W: dq_o = wf_empty_i ? 8'hFF : wf_head_i;
      S_CMD2:   dq_o = cmd_q.cmd2;
      default:  dq_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int DLEN_W     = 12,
  parameter int AHI_W      = 24,
  parameter int PULSE_CYC  = 2,
  parameter int TWB_CYC    = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic [1:0]  nand_ce_no,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_no,
  output logic        nand_re_no,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe_o,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_ni
);
  localparam int AW = 16 + AHI_W;

  logic              busy, done_set, launch;
  seq_cmd_t          cmd;
  logic [AW-1:0]     addr;
  logic [DLEN_W-1:0] dlen;
  logic              rf_pop, rf_push, rf_empty;
  logic [7:0]        rf_head, rf_data;
  logic              wf_push, wf_pop, wf_empty;
  logic [7:0]        wf_head;
  logic              rf_empty_unused;

  assign rf_empty_unused = rf_empty;

  nand_seq_regs #(.DLEN_W(DLEN_W), .AHI_W(AHI_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_set_i(done_set), .rf_head_i(rf_head), .rf_pop_o(rf_pop),
    .wf_push_o(wf_push), .launch_o(launch), .cmd_o(cmd), .addr_o(addr),
    .dlen_o(dlen), .done_o(irq_o)
  );

  nand_seq_fsm #(.DLEN_W(DLEN_W), .AW(AW), .PULSE_CYC(PULSE_CYC), .TWB_CYC(TWB_CYC)) u_fsm (
    .clk_i, .rst_ni, .launch_i(launch), .cmd_i(cmd), .addr_i(addr), .dlen_i(dlen),
    .wf_empty_i(wf_empty), .wf_head_i(wf_head), .wf_pop_o(wf_pop),
    .rf_push_o(rf_push), .rf_data_o(rf_data), .busy_o(busy), .done_set_o(done_set),
    .ce_no(nand_ce_no), .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no),
    .re_no(nand_re_no), .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o), .dq_i(nand_dq_i),
    .rb_ni(nand_rb_ni)
  );

  nand_seq_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rd_fifo (
    .clk_i, .rst_ni, .push_i(rf_push), .data_i(rf_data), .pop_i(rf_pop),
    .head_o(rf_head), .empty_o(rf_empty)
  );

  nand_seq_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_wr_fifo (
    .clk_i, .rst_ni, .push_i(wf_push), .data_i(reg_wdata_i[7:0]), .pop_i(wf_pop),
    .head_o(wf_head), .empty_o(wf_empty)
  );
endmodule

// File: rtl/nand_seq_sva.sv
module nand_seq_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic [2:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        irq_o,
  input logic [1:0]  nand_ce_no,
  input logic        nand_cle_o,
  input logic        nand_ale_o,
  input logic        nand_we_no,
  input logic        nand_re_no,
  input logic [7:0]  nand_dq_o,
  input logic        nand_dq_oe_o,
  input logic        busy_i
);
  a_r1_start_needs_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[31]));

  a_r2_cle_ale_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  a_r2_bus_held_at_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> $stable(nand_dq_o) && $stable(nand_cle_o) && $stable(nand_ale_o));

  a_r6_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o && !nand_cle_o && !nand_ale_o && nand_we_no);

  a_r8_one_ce_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> $countones(~nand_ce_no) == 1);

  a_r8_ce_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> nand_ce_no == 2'b11);

  a_r10_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd5 && reg_wdata_i[31] && !busy_i) |=> !irq_o);

  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_i));
endmodule

bind nand_seq_top nand_seq_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .nand_ce_no(nand_ce_no),
  .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_no(nand_we_no),
  .nand_re_no(nand_re_no), .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o),
  .busy_i(busy)
);

// File: tb/nand_seq_top_tb.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;
  localparam int BUSY_LEN = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic [1:0]  nand_ce_no;
  logic        nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_dq_oe_o;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i;
  logic        nand_rb_ni;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  nand_seq_top dut_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .irq_o, .nand_ce_no, .nand_cle_o, .nand_ale_o, .nand_we_no, .nand_re_no,
    .nand_dq_o, .nand_dq_oe_o, .nand_dq_i, .nand_rb_ni
  );

  // flash model: logs latched bytes as {cle,ale,dq}, goes busy after confirm opcodes
  logic [9:0] log_v [0:255];
  logic [1:0] log_ce [0:255];
  int log_n = 0, rd_idx = 0, busy_cnt = 0, busy_events = 0, viol = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;

  assign nand_rb_ni = !(busy_cnt > 0 && busy_cnt <= BUSY_LEN);
  assign nand_dq_i  = 8'hA0 + rd_idx[7:0];

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      we_prev = 1'b1;
      re_prev = 1'b1;
    end else begin
      if (!we_prev && nand_we_no) begin
        if (log_n < 256) begin
          log_v[log_n]  = {nand_cle_o, nand_ale_o, nand_dq_o};
          log_ce[log_n] = nand_ce_no;
          log_n++;
        end
        if (nand_cle_o && (nand_dq_o == 8'h30 || nand_dq_o == 8'h10 || nand_dq_o == 8'hD0))
          busy_cnt = BUSY_LEN + 2;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == BUSY_LEN) busy_events++;
      end
      if (!re_prev && nand_re_no) rd_idx++;
      if (!nand_re_no && !nand_rb_ni) viol++;
      if (irq_o && !nand_rb_ni) viol++;
      we_prev = nand_we_no;
      re_prev = nand_re_no;
    end
  end

  function automatic logic [9:0] ce_(input logic [7:0] b); return {2'b10, b}; endfunction
  function automatic logic [9:0] ae_(input logic [7:0] b); return {2'b01, b}; endfunction
  function automatic logic [9:0] de_(input logic [7:0] b); return {2'b00, b}; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic reg_pop(output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = 3'd6;
    #1 v = reg_rdata_o;
    reg_rd_i = 1'b1;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!irq_o && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    chk(tag, 32'(irq_o), 32'd1);
  endtask

  task automatic clear_done();
    reg_write(3'd5, 32'h8000_0000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 ce", 32'(nand_ce_no), 32'h3);
    chk("R12 cle/ale", {30'b0, nand_cle_o, nand_ale_o}, 32'h0);
    chk("R12 we/re", {30'b0, nand_we_no, nand_re_no}, 32'h3);
    chk("R12 oe/irq", {30'b0, nand_dq_oe_o, irq_o}, 32'h0);
    reg_read(3'd5, v);
    chk("R12 status", v, 32'h0);
  endtask

  task automatic t_read_page();
    logic [31:0] v;
    int b, r0, be0, v0;
    b = log_n; r0 = rd_idx; be0 = busy_events; v0 = viol;
    reg_write(3'd1, 32'h0000_0130);
    reg_write(3'd2, 32'h0000_0034);
    reg_write(3'd3, 32'h0000_5678);
    reg_write(3'd4, 32'd4);
    reg_write(3'd0, 32'hE400_0000);
    wait_done("R10 read page done");
    chk("R2 first cmd", 32'(log_v[b]), 32'(ce_(8'h00)));
    chk("R3 addr0", 32'(log_v[b+1]), 32'(ae_(8'h34)));
    chk("R3 addr1", 32'(log_v[b+2]), 32'(ae_(8'h00)));
    chk("R3 addr2", 32'(log_v[b+3]), 32'(ae_(8'h78)));
    chk("R3 addr3", 32'(log_v[b+4]), 32'(ae_(8'h56)));
    chk("R3 addr4", 32'(log_v[b+5]), 32'(ae_(8'h00)));
    chk("R4 read start", 32'(log_v[b+6]), 32'(ce_(8'h30)));
    chk("R3 count", log_n - b, 7);
    chk("R8 ce0", 32'(log_ce[b+3]), 32'h2);
    chk("R9 busy seen", busy_events - be0, 1);
    chk("R9 no early data", viol - v0, 0);
    chk("R5 read count", rd_idx - r0, 4);
    for (int k = 0; k < 4; k++) begin
      reg_pop(v);
      chk("R6 read byte", v, 32'(8'hA0 + 8'(r0 + k)));
    end
    reg_write(3'd5, 32'h0000_0000);
    chk("R10 write 0 keeps", 32'(irq_o), 32'd1);
    reg_read(3'd5, v);
    chk("R10 status done", v, 32'h8000_0000);
    clear_done();
    chk("R10 w1c", 32'(irq_o), 32'd0);
  endtask

  task automatic t_read_id();
    logic [31:0] v;
    int b, r0, be0;
    b = log_n; r0 = rd_idx; be0 = busy_events;
    reg_write(3'd1, 32'h0000_0030);
    reg_write(3'd2, 32'h0000_0000);
    reg_write(3'd3, 32'h0000_0000);
    reg_write(3'd4, 32'd2);
    reg_write(3'd0, 32'hC400_0090);
    wait_done("R9 timeout path done");
    chk("R2 id cmd", 32'(log_v[b]), 32'(ce_(8'h90)));
    chk("R3 one addr", 32'(log_v[b+1]), 32'(ae_(8'h00)));
    chk("R4 cmd2 off", log_n - b, 2);
    chk("R9 no busy", busy_events - be0, 0);
    for (int k = 0; k < 2; k++) begin
      reg_pop(v);
      chk("R6 id byte", v, 32'(8'hA0 + 8'(r0 + k)));
    end
    clear_done();
  endtask

  task automatic t_program();
    logic [31:0] v;
    int b, be0, r0;
    b = log_n; be0 = busy_events; r0 = rd_idx;
    reg_write(3'd7, 32'h11);
    reg_write(3'd7, 32'h22);
    reg_write(3'd7, 32'h33);
    reg_write(3'd1, 32'h0000_0110);
    reg_write(3'd2, 32'h0000_0800);
    reg_write(3'd3, 32'h0000_0000);
    reg_write(3'd4, 32'd4);
    reg_write(3'd0, 32'hCA08_0080);
    reg_read(3'd5, v);
    chk("R11 busy flag", v, 32'h0000_0001);
    reg_write(3'd0, 32'hC400_0090);
    wait_done("R10 program done");
    chk("R11 ignored launch count", log_n - b, 8);
    chk("R2 prog cmd", 32'(log_v[b]), 32'(ce_(8'h80)));
    chk("R3 col lo", 32'(log_v[b+1]), 32'(ae_(8'h00)));
    chk("R3 col hi", 32'(log_v[b+2]), 32'(ae_(8'h08)));
    chk("R7 data0", 32'(log_v[b+3]), 32'(de_(8'h11)));
    chk("R7 data1", 32'(log_v[b+4]), 32'(de_(8'h22)));
    chk("R7 data2", 32'(log_v[b+5]), 32'(de_(8'h33)));
    chk("R7 empty ff", 32'(log_v[b+6]), 32'(de_(8'hFF)));
    chk("R4 confirm after data", 32'(log_v[b+7]), 32'(ce_(8'h10)));
    for (int k = 0; k < 8; k++) chk("R8 ce1", 32'(log_ce[b+k]), 32'h1);
    chk("R9 prog busy", busy_events - be0, 1);
    chk("R5 no read", rd_idx - r0, 0);
    reg_read(3'd0, v);
    chk("R1 readback", v, 32'hCA08_0080);
    reg_read(3'd5, v);
    chk("R11 busy clear", v, 32'h8000_0000);
    clear_done();
  endtask

  task automatic t_erase();
    int b, v0, r0;
    b = log_n; v0 = viol; r0 = rd_idx;
    reg_write(3'd1, 32'h0000_01D0);
    reg_write(3'd2, 32'h0000_4321);
    reg_write(3'd3, 32'h0000_0065);
    reg_write(3'd0, 32'hD000_0060);
    wait_done("R10 erase done");
    chk("R2 erase cmd", 32'(log_v[b]), 32'(ce_(8'h60)));
    chk("R3 row0", 32'(log_v[b+1]), 32'(ae_(8'h21)));
    chk("R3 row1", 32'(log_v[b+2]), 32'(ae_(8'h43)));
    chk("R3 row2", 32'(log_v[b+3]), 32'(ae_(8'h65)));
    chk("R4 erase confirm", 32'(log_v[b+4]), 32'(ce_(8'hD0)));
    chk("R9 done after ready", viol - v0, 0);
    chk("R5 no data phase", rd_idx - r0, 0);
    clear_done();
  endtask

  task automatic t_no_addr();
    logic [31:0] v;
    int b;
    b = log_n;
    reg_write(3'd1, 32'h0000_0030);
    reg_write(3'd0, 32'h0000_00AA);
    repeat (10) @(negedge clk_i);
    chk("R1 no valid no op", log_n - b, 0);
    reg_read(3'd5, v);
    chk("R1 still idle", v, 32'h0);
    reg_write(3'd0, 32'h8000_00FF);
    wait_done("R10 reset cmd done");
    chk("R3 no addr count", log_n - b, 1);
    chk("R2 reset cmd", 32'(log_v[b]), 32'(ce_(8'hFF)));
    clear_done();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_read_page();
    t_read_id();
    t_program();
    t_erase();
    t_no_addr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule